// File: doc/BRIEF.md
# Programmable Shift Clock Generator

This block produces the serial shift clock for a command-driven serial engine. A decoder in front of it issues one command per cycle on a valid/opcode/argument interface. Some commands only configure the block: the 16-bit divider, the divide-by-5 prescaler, adaptive clocking and the clock's idle level. The others start an activity. That activity is a clock-only burst with no data, a stall until a general-purpose input reaches a level, or clocking that stops when that input reaches a level, when a bit count runs out, or on whichever of the two comes first.

The clock period is the core clock divided by P and then by 2×(D+1). D is the 16-bit divider, and P is 5 while the prescaler is on and 1 while it is off. In adaptive mode each edge also waits until the returned clock has followed the previous edge. The level input and the returned clock each pass through a two-flop synchronizer. The block reports every pin toggle on an edge strobe and shows a busy level while a command is active. A one-cycle done pulse marks the end of that command.

A command is accepted only while the block is idle. Configuration is copied into the divider only while no clock is running, so a new setting always starts on a whole period.

Top module: `sclk_gen`

## Requirements
- R1: While clocking, every half period of `sclk` lasts (D+1)×P core cycles, with D the programmed divider and P = 5 (prescaler on) or 1 (off). The first edge comes (D+1)×P cycles after the edge that accepts the command.
- R2: After reset, `sclk`, `busy`, `done` and `edge_stb` are low, the divider is 0, the prescaler is on, adaptive clocking is off and the idle level is 0.
- R3: Opcode 7 with argument N produces exactly N+1 full clock periods (2N+2 toggles, each flagged by `edge_stb`) and ends with `sclk` at the idle level.
- R4: Opcode 8 with argument N produces (N+1)×8 full clock periods.
- R5: Opcodes 9 (high) and 10 (low) stall with no toggle until the synchronized level input equals the target. `done` rises three cycles after the input changes, or one cycle after acceptance if the input already matches.
- R6: Opcodes 11 (high) and 12 (low) clock without a count. The command ends on the first cycle in which `sclk` is at the idle level and the synchronized level input matches the target, so no toggle occurs if the input already matches.
- R7: Opcodes 13 (high) and 14 (low) with argument N end after N+1 periods or on the level condition of R6, whichever comes first.
- R8: With adaptive clocking on (opcode 4; opcode 5 turns it off), a toggle waits until the synchronized returned clock equals the current `sclk` level. With it off, the returned clock has no effect.
- R9: Opcode 6 sets the idle level to argument bit 0, and `sclk` rests at that level while idle.
- R10: Opcodes 1 (divider = argument), 2 (prescaler on) and 3 (prescaler off) apply to the next command. Any command presented while `busy` is high is ignored.
- R11: `busy` is high from the cycle after acceptance until the command ends. `done` is then high for exactly one cycle, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_arg | input | ARG_W | Command argument |
| io1_in | input | 1 | Level input watched by wait commands |
| rtclk_in | input | 1 | Returned clock for adaptive mode |
| sclk | output | 1 | Shift clock pin |
| edge_stb | output | 1 | High in the cycle after each `sclk` toggle |
| busy | output | 1 | A burst or wait is active |
| done | output | 1 | One-cycle pulse when a burst or wait ends |

## Verification
The bench keeps the default parameters, ARG_W = 16 and a prescaler ratio of 5. It sweeps every combination of divider 0 to 3, prescaler on and off, and bit counts 1 to 4. At each point it compares the first-edge time, the toggle count and the completion cycle with (D+1)×P arithmetic. With divider values this small, the cycle-exact timing of level stops, of races between the count and the level, and of adaptive stalls can be predicted by hand. That timing includes the synchronizer latency.

// File: rtl/sclk_pkg.sv
`timescale 1ns/1ps
package sclk_pkg;

  typedef enum logic [3:0] {
    OP_NOP        = 4'd0,
    OP_SET_DIV    = 4'd1,
    OP_PRE_ON     = 4'd2,
    OP_PRE_OFF    = 4'd3,
    OP_ADAPT_ON   = 4'd4,
    OP_ADAPT_OFF  = 4'd5,
    OP_SET_IDLE   = 4'd6,
    OP_CLK_BITS   = 4'd7,
    OP_CLK_BYTES  = 4'd8,
    OP_WAIT_HI    = 4'd9,
    OP_WAIT_LO    = 4'd10,
    OP_CLKWAIT_HI = 4'd11,
    OP_CLKWAIT_LO = 4'd12,
    OP_CBWAIT_HI  = 4'd13,
    OP_CBWAIT_LO  = 4'd14
  } sclk_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CLK  = 2'd1,
    ST_WAIT = 2'd2
  } sclk_state_e;

endpackage

// File: rtl/sclk_sync2.sv
`timescale 1ns/1ps
module sclk_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d_i;
      hold_q <= meta_q;
    end
  end

  assign q_o = hold_q;

endmodule

// File: rtl/sclk_tick_div.sv
`timescale 1ns/1ps
module sclk_tick_div #(
  parameter int ARG_W   = 16,
  parameter int PRE_DIV = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [ARG_W-1:0] div_i,
  input  logic             pre_en_i,
  output logic             half_tick_o
);

  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic [ARG_W-1:0] div_a_q, div_a_n;
  logic             pre_a_q, pre_a_n;
  logic [ARG_W-1:0] div_cnt_q, div_cnt_n;
  logic             base_tick;
  logic             div_wrap;

  // settings follow the staged values only while no clock runs
  always_comb begin
    div_a_n = div_a_q;
    pre_a_n = pre_a_q;
    if (!run_i) begin
      div_a_n = div_i;
      pre_a_n = pre_en_i;
    end
  end

  generate
    if (PRE_DIV > 1) begin : g_pre
      logic [PW-1:0] pre_cnt_q, pre_cnt_n;
      logic          pre_last;

      assign pre_last  = (pre_cnt_q == PW'(PRE_DIV - 1));
      assign base_tick = pre_a_q ? pre_last : 1'b1;

      always_comb begin
        pre_cnt_n = pre_cnt_q;
        if (!run_i || !pre_a_q) begin
          pre_cnt_n = '0;
        end else if (pre_last) begin
          pre_cnt_n = '0;
        end else begin
          pre_cnt_n = pre_cnt_q + PW'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pre_cnt_q <= '0;
        end else begin
          pre_cnt_q <= pre_cnt_n;
        end
      end
    end else begin : g_nopre
      assign base_tick = 1'b1;
    end
  endgenerate

  assign div_wrap    = (div_cnt_q == div_a_q);
  assign half_tick_o = run_i && base_tick && div_wrap;

  always_comb begin
    div_cnt_n = div_cnt_q;
    if (!run_i) begin
      div_cnt_n = '0;
    end else if (base_tick) begin
      div_cnt_n = div_wrap ? '0 : div_cnt_q + ARG_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_a_q   <= '0;
      pre_a_q   <= 1'b1;
      div_cnt_q <= '0;
    end else begin
      div_a_q   <= div_a_n;
      pre_a_q   <= pre_a_n;
      div_cnt_q <= div_cnt_n;
    end
  end

  // cycles since the clock started or since the previous half tick
  logic [31:0] chk_gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_gap_q <= '0;
    end else if (!run_i || half_tick_o) begin
      chk_gap_q <= '0;
    end else begin
      chk_gap_q <= chk_gap_q + 32'd1;
    end
  end

  // R1
  half_period_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick_o |-> (chk_gap_q == (32'(div_a_q) + 32'd1) * (pre_a_q ? PRE_DIV : 1) - 32'd1));

endmodule

// File: rtl/sclk_seq.sv
`timescale 1ns/1ps
module sclk_seq
  import sclk_pkg::*;
#(
  parameter int ARG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_op,
  input  logic [ARG_W-1:0] cmd_arg,
  input  logic             io1_s,
  input  logic             rtck_s,
  input  logic             half_tick,
  output logic             run_o,
  output logic [ARG_W-1:0] div_o,
  output logic             pre_en_o,
  output logic             sclk_o,
  output logic             edge_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam int CNT_W = ARG_W + 4;

  sclk_state_e      state_q, state_n;
  logic [ARG_W-1:0] div_q, div_n;
  logic             pre_q, pre_n;
  logic             adapt_q, adapt_n;
  logic             idle_q, idle_n;
  logic             lvl_q, lvl_n;
  logic             stopc_q, stopc_n;
  logic             limit_q, limit_n;
  logic [CNT_W-1:0] bits_q, bits_n;
  logic             sclk_q, sclk_n;
  logic             done_q, done_n;
  logic             edge_q, edge_n;

  logic [CNT_W-1:0] arg_p1;
  logic             at_idle;
  logic             lvl_hit;
  logic             may_toggle;

  assign arg_p1     = CNT_W'(cmd_arg) + CNT_W'(1);
  assign at_idle    = (sclk_q == idle_q);
  assign lvl_hit    = (io1_s == lvl_q);
  assign may_toggle = half_tick && (!adapt_q || (rtck_s == sclk_q));

  always_comb begin
    state_n = state_q;
    div_n   = div_q;
    pre_n   = pre_q;
    adapt_n = adapt_q;
    idle_n  = idle_q;
    lvl_n   = lvl_q;
    stopc_n = stopc_q;
    limit_n = limit_q;
    bits_n  = bits_q;
    sclk_n  = sclk_q;
    done_n  = 1'b0;
    edge_n  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        sclk_n = idle_q;
        if (cmd_valid) begin
          case (sclk_op_e'(cmd_op))
            OP_SET_DIV:   div_n   = cmd_arg;
            OP_PRE_ON:    pre_n   = 1'b1;
            OP_PRE_OFF:   pre_n   = 1'b0;
            OP_ADAPT_ON:  adapt_n = 1'b1;
            OP_ADAPT_OFF: adapt_n = 1'b0;
            OP_SET_IDLE:  idle_n  = cmd_arg[0];
            OP_CLK_BITS: begin
              bits_n  = arg_p1;
              limit_n = 1'b1;
              stopc_n = 1'b0;
              state_n = ST_CLK;
            end
            OP_CLK_BYTES: begin
              bits_n  = arg_p1 << 3;
              limit_n = 1'b1;
              stopc_n = 1'b0;
              state_n = ST_CLK;
            end
            OP_WAIT_HI, OP_WAIT_LO: begin
              lvl_n   = (sclk_op_e'(cmd_op) == OP_WAIT_HI);
              state_n = ST_WAIT;
            end
            OP_CLKWAIT_HI, OP_CLKWAIT_LO: begin
              lvl_n   = (sclk_op_e'(cmd_op) == OP_CLKWAIT_HI);
              limit_n = 1'b0;
              stopc_n = 1'b1;
              state_n = ST_CLK;
            end
            OP_CBWAIT_HI, OP_CBWAIT_LO: begin
              lvl_n   = (sclk_op_e'(cmd_op) == OP_CBWAIT_HI);
              bits_n  = arg_p1;
              limit_n = 1'b1;
              stopc_n = 1'b1;
              state_n = ST_CLK;
            end
            default: ;
          endcase
        end
      end
      ST_CLK: begin
        if (stopc_q && at_idle && lvl_hit) begin
          state_n = ST_IDLE;
          done_n  = 1'b1;
        end else if (may_toggle) begin
          sclk_n = ~sclk_q;
          edge_n = 1'b1;
          if (!at_idle && limit_q) begin
            bits_n = bits_q - CNT_W'(1);
            if (bits_q == CNT_W'(1)) begin
              state_n = ST_IDLE;
              done_n  = 1'b1;
            end
          end
        end
      end
      ST_WAIT: begin
        if (lvl_hit) begin
          state_n = ST_IDLE;
          done_n  = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      div_q   <= '0;
      pre_q   <= 1'b1;
      adapt_q <= 1'b0;
      idle_q  <= 1'b0;
      lvl_q   <= 1'b0;
      stopc_q <= 1'b0;
      limit_q <= 1'b0;
      bits_q  <= '0;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
      edge_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      div_q   <= div_n;
      pre_q   <= pre_n;
      adapt_q <= adapt_n;
      idle_q  <= idle_n;
      lvl_q   <= lvl_n;
      stopc_q <= stopc_n;
      limit_q <= limit_n;
      bits_q  <= bits_n;
      sclk_q  <= sclk_n;
      done_q  <= done_n;
      edge_q  <= edge_n;
    end
  end

  assign run_o    = (state_q == ST_CLK);
  assign div_o    = div_q;
  assign pre_en_o = pre_q;
  assign sclk_o   = sclk_q;
  assign edge_o   = edge_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;

  // R1
  tick_only_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CLK) && !half_tick |=> $stable(sclk_q));

  // R5
  wait_no_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |=> $stable(sclk_q));

  // R8
  adapt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adapt_q && (state_q == ST_CLK) && (rtck_s != sclk_q) |=> $stable(sclk_q));

  // R10
  busy_cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(div_q) && $stable(idle_q) && $stable(pre_q));

  // R3
  end_at_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (sclk_q == idle_q));

  // R11
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

endmodule

// File: rtl/sclk_gen.sv
`timescale 1ns/1ps
module sclk_gen #(
  parameter int ARG_W   = 16,
  parameter int PRE_DIV = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_op,
  input  logic [ARG_W-1:0] cmd_arg,
  input  logic             io1_in,
  input  logic             rtclk_in,
  output logic             sclk,
  output logic             edge_stb,
  output logic             busy,
  output logic             done
);

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [1:0]       in_sync;
  logic             half_tick;
  logic             run;
  logic [ARG_W-1:0] div_stage;
  logic             pre_stage;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  sclk_sync2 #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   ({rtclk_in, io1_in}),
    .q_o   (in_sync)
  );

  sclk_tick_div #(.ARG_W(ARG_W), .PRE_DIV(PRE_DIV)) u_div (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .run_i       (run),
    .div_i       (div_stage),
    .pre_en_i    (pre_stage),
    .half_tick_o (half_tick)
  );

  sclk_seq #(.ARG_W(ARG_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_arg   (cmd_arg),
    .io1_s     (in_sync[0]),
    .rtck_s    (in_sync[1]),
    .half_tick (half_tick),
    .run_o     (run),
    .div_o     (div_stage),
    .pre_en_o  (pre_stage),
    .sclk_o    (sclk),
    .edge_o    (edge_stb),
    .busy_o    (busy),
    .done_o    (done)
  );

endmodule

// File: tb/sclk_gen_tb.sv
`timescale 1ns/1ps
module sclk_gen_tb_top;
  import sclk_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = 4'd0;
  logic [15:0] cmd_arg = 16'd0;
  logic        io1_in = 1'b0;
  logic        rtclk_in = 1'b0;
  logic        sclk, edge_stb, busy, done;

  int n_cmp = 0;
  int n_bad = 0;
  int m_k, m_edges, m_first;
  bit m_done, m_busy_ok;

  always #2.5 clk = ~clk;

  sclk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .io1_in(io1_in), .rtclk_in(rtclk_in),
    .sclk(sclk), .edge_stb(edge_stb), .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input sclk_op_e op, input int arg);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_arg   = 16'(arg);
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    cmd_op    = 4'd0;
    cmd_arg   = 16'd0;
  endtask

  task automatic measure(input int limit);
    m_k = 0; m_edges = 0; m_first = -1; m_done = 1'b0; m_busy_ok = 1'b1;
    while (!m_done && m_k < limit) begin
      @(posedge clk);
      m_k++;
      @(negedge clk);
      if (edge_stb) begin
        m_edges++;
        if (m_first < 0) m_first = m_k;
      end
      if (done) m_done = 1'b1;
      else if (!busy) m_busy_ok = 1'b0;
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    settle(4);
    rst_n = 1'b1;
    settle(5);
    // R2 reset state
    chk("R2 sclk", sclk, 0);
    chk("R2 busy", busy, 0);
    chk("R2 done", done, 0);
    chk("R2 edge_stb", edge_stb, 0);

    // R2 defaults: div 0, prescaler on -> half period 5
    do_cmd(OP_CLK_BITS, 0);
    measure(100);
    chk("R2 first edge", m_first, 5);
    chk("R2 done cycle", m_k, 10);
    chk("R2 edges", m_edges, 2);

    // R1 R3 R10 R11 sweep
    for (int p = 0; p < 2; p++) begin
      do_cmd(p ? OP_PRE_ON : OP_PRE_OFF, 0);
      for (int d = 0; d < 4; d++) begin
        do_cmd(OP_SET_DIV, d);
        for (int n = 0; n < 4; n++) begin
          int h;
          h = (d + 1) * (p ? 5 : 1);
          do_cmd(OP_CLK_BITS, n);
          measure(2000);
          chk("R1 first edge", m_first, h);
          chk("R3 edges", m_edges, 2 * (n + 1));
          chk("R10 done cycle", m_k, 2 * (n + 1) * h);
          chk("R11 busy held", m_busy_ok, 1);
          @(negedge clk);
          chk("R11 done one cycle", done, 0);
          chk("R3 idle at end", sclk, 0);
        end
      end
    end

    // R4 bytes, prescaler off, div 0
    do_cmd(OP_PRE_OFF, 0);
    do_cmd(OP_SET_DIV, 0);
    for (int n = 0; n < 2; n++) begin
      do_cmd(OP_CLK_BYTES, n);
      measure(2000);
      chk("R4 edges", m_edges, 16 * (n + 1));
      chk("R4 done cycle", m_k, 16 * (n + 1));
    end

    // R5 wait without clock
    io1_in = 1'b0;
    settle(4);
    do_cmd(OP_WAIT_HI, 0);
    measure(10);
    chk("R5 stalled", m_done, 0);
    chk("R5 no edges", m_edges, 0);
    chk("R5 busy", busy, 1);
    io1_in = 1'b1;
    measure(20);
    chk("R5 done after sync", m_k, 3);
    chk("R5 no edges", m_edges, 0);
    do_cmd(OP_WAIT_HI, 0);
    measure(20);
    chk("R5 already met", m_k, 1);

    // R6 clock until level, div 1 (half period 2)
    do_cmd(OP_SET_DIV, 1);
    do_cmd(OP_CLKWAIT_LO, 0);
    measure(20);
    chk("R6 running", m_done, 0);
    chk("R6 edges", m_edges, 10);
    io1_in = 1'b0;
    measure(40);
    chk("R6 stop cycle", m_k, 5);
    chk("R6 stop edges", m_edges, 2);
    chk("R6 idle", sclk, 0);
    do_cmd(OP_CLKWAIT_LO, 0);
    measure(20);
    chk("R6 already met", m_k, 1);
    chk("R6 already met edges", m_edges, 0);

    // R7 count or level, whichever first
    io1_in = 1'b1;
    settle(4);
    do_cmd(OP_CBWAIT_LO, 2);
    measure(100);
    chk("R7 count edges", m_edges, 6);
    chk("R7 count cycle", m_k, 12);
    do_cmd(OP_CBWAIT_HI, 5);
    measure(100);
    chk("R7 level met", m_k, 1);
    do_cmd(OP_CBWAIT_LO, 7);
    measure(8);
    chk("R7 running", m_edges, 4);
    io1_in = 1'b0;
    measure(40);
    chk("R7 level first cycle", m_k, 5);
    chk("R7 level first edges", m_edges, 2);

    // R8 adaptive
    do_cmd(OP_SET_DIV, 0);
    do_cmd(OP_ADAPT_ON, 0);
    rtclk_in = 1'b0;
    settle(3);
    do_cmd(OP_CLK_BITS, 0);
    measure(20);
    chk("R8 first edge", m_first, 1);
    chk("R8 stalled edges", m_edges, 1);
    chk("R8 stalled", m_done, 0);
    rtclk_in = 1'b1;
    measure(20);
    chk("R8 release cycle", m_k, 3);
    chk("R8 release edges", m_edges, 1);
    do_cmd(OP_ADAPT_OFF, 0);
    rtclk_in = 1'b0;
    settle(3);

    // R9 idle level
    do_cmd(OP_SET_IDLE, 1);
    settle(3);
    chk("R9 idle high", sclk, 1);
    do_cmd(OP_CLK_BITS, 1);
    measure(100);
    chk("R9 edges", m_edges, 4);
    settle(1);
    chk("R9 end high", sclk, 1);
    do_cmd(OP_SET_IDLE, 0);
    settle(3);
    chk("R9 idle low", sclk, 0);

    // R10 commands during a burst are ignored
    do_cmd(OP_CLK_BITS, 7);
    do_cmd(OP_SET_IDLE, 1);
    measure(100);
    chk("R10 burst cycle", m_k, 15);
    settle(3);
    chk("R10 idle unchanged", sclk, 0);
    do_cmd(OP_CLK_BITS, 3);
    do_cmd(OP_SET_DIV, 3);
    measure(100);
    chk("R10 burst2 cycle", m_k, 7);
    do_cmd(OP_CLK_BITS, 0);
    measure(100);
    chk("R10 div unchanged", m_k, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule